// File: doc/BRIEF.md
# Weighted Two-Queue Transmit Arbiter

This block chooses, one packet at a time, whether the high-priority or the low-priority transmit queue supplies the next packet. A 3-bit weight code sets how many high-priority packets may go out before one low-priority packet is let through. One code selects strict priority instead. Once a packet has been granted, the grant stays fixed until the packet-done strobe marks its end. Only then is the next owner chosen.

Each queue reports whether it holds a packet. Each queue also has its own run enable, and a queue that is stopped is treated as having nothing to send. A counter tracks how many high-priority packets have gone in the current run. It is cleared whenever a low-priority packet wins because the high queue had nothing eligible, or because the quota was reached. If the quota is reached while the low queue has nothing to send, high service goes on and a fresh run starts with the packet just granted. When neither queue can be served, the grant is withdrawn and the counter keeps its value.

Top module: `txq_weighted_arb`

## Requirements
- R1: While reset is asserted, grant is 2'b00, grant_valid is 0 and the high-packet count is zero.
- R2: grant bit 0 means the high queue and bit 1 means the low queue. At most one bit is set, and grant_valid is 1 exactly when a bit is set.
- R3: A decision is taken on a rising edge where grant_valid is 0 or pkt_done is 1, and it shows on the outputs after that edge. While grant_valid is 1 and pkt_done is 0, the grant does not change. A pkt_done pulse while grant_valid is 0 has no effect beyond the normal idle decision.
- R4: A queue is eligible only when its pending flag and its run enable are both 1. No new grant is given to a queue that is not eligible.
- R5: When both queues stay eligible and the weight code is 0 to 6, the low queue gets one packet after a run of Q high packets. Q is 1, 2, 4, 6, 8, 10 or 12 for codes 0, 1, 2, 3, 4, 5 and 6.
- R6: With weight code 7, the high queue wins every decision in which it is eligible.
- R7: A decision that grants the low queue clears the high-packet count, including the case where the high queue was not eligible before its quota was used. The next run therefore starts from zero.
- R8: If the count has reached Q and only the high queue is eligible, the high queue is granted and the count restarts at one.
- R9: If neither queue is eligible at a decision, grant_valid goes to 0 and the count keeps its value. Service later resumes from the kept count.
- R10: The weight code is sampled only at a decision. A change in the middle of a packet has no effect until the next boundary, and it then applies against the count already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_pending | input | 1 | High queue holds a packet |
| lo_pending | input | 1 | Low queue holds a packet |
| hi_run | input | 1 | High queue run enable |
| lo_run | input | 1 | Low queue run enable |
| weight_code | input | 3 | High-per-low weight code (7 = strict) |
| pkt_done | input | 1 | Current packet finishes this cycle |
| grant | output | 2 | One-hot owner: bit 0 high, bit 1 low |
| grant_valid | output | 1 | A packet is granted and in progress |

## Verification
The hardest cases to reach are those that depend on the hidden count. The first is the high queue running dry partway through a run. The second is both queues going idle with the count held, and the third is a weight change that lands against a count already accumulated. None of these can be seen on the ports directly, only through the order of later grants. The stimulus therefore first drains the count by forcing a low-only boundary. It then changes the pending and run flags strictly between packets, so the count reaches known values. The number of high packets that precede the next low grant is then compared with the value expected when the count was kept, which differs from the value expected if it had been cleared.

// File: rtl/txq_weighted_arb.sv
module txq_weighted_arb #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hi_pending,
  input  logic       lo_pending,
  input  logic       hi_run,
  input  logic       lo_run,
  input  logic [2:0] weight_code,
  input  logic       pkt_done,
  output logic [1:0] grant,
  output logic       grant_valid
);

  localparam logic [2:0]       STRICT_CODE = 3'b111;
  localparam logic [CNT_W-1:0] ONE         = CNT_W'(1);

  logic             hi_ok, lo_ok, boundary, strict, quota_met;
  logic             pick_hi, pick_lo;
  logic [CNT_W-1:0] hi_cnt, quota, cnt_nxt;

  assign hi_ok    = hi_pending & hi_run;
  assign lo_ok    = lo_pending & lo_run;
  assign boundary = ~grant_valid | pkt_done;
  assign strict   = weight_code == STRICT_CODE;

  // codes 1..6 give twice the code; code 0 gives one
  assign quota     = (weight_code == 3'd0) ? ONE : CNT_W'({weight_code, 1'b0});
  assign quota_met = hi_cnt >= quota;

  assign pick_lo = lo_ok & (~hi_ok | (~strict & quota_met));
  assign pick_hi = hi_ok & ~pick_lo;

  always_comb begin
    if (!hi_ok && !lo_ok)      cnt_nxt = hi_cnt;
    else if (pick_lo || strict) cnt_nxt = '0;
    else if (quota_met)         cnt_nxt = ONE;
    else                        cnt_nxt = hi_cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant       <= 2'b00;
      grant_valid <= 1'b0;
      hi_cnt      <= '0;
    end else if (boundary) begin
      grant       <= {pick_lo, pick_hi};
      grant_valid <= pick_lo | pick_hi;
      hi_cnt      <= cnt_nxt;
    end
  end

endmodule

// File: rtl/txq_weighted_arb_chk.sv
module txq_weighted_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hi_pending,
  input logic       lo_pending,
  input logic       hi_run,
  input logic       lo_run,
  input logic [2:0] weight_code,
  input logic       pkt_done,
  input logic [1:0] grant,
  input logic       grant_valid
);

  logic decide, hi_e, lo_e;
  assign decide = ~grant_valid | pkt_done;
  assign hi_e   = hi_pending & hi_run;
  assign lo_e   = lo_pending & lo_run;

  p_grant_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != 2'b00)));

  p_hold_mid_packet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !pkt_done |=> grant_valid && $stable(grant));

  p_no_ineligible_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !hi_e |=> !grant[0]);

  p_no_ineligible_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !lo_e |=> !grant[1]);

  p_strict_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    decide && hi_e && weight_code == 3'b111 |=> grant == 2'b01);

  p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    decide && !hi_e && !lo_e |=> !grant_valid);

endmodule

bind txq_weighted_arb txq_weighted_arb_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hi_pending(hi_pending), .lo_pending(lo_pending),
  .hi_run(hi_run), .lo_run(lo_run), .weight_code(weight_code),
  .pkt_done(pkt_done), .grant(grant), .grant_valid(grant_valid)
);

// File: tb/test_txq_weighted_arb.sv
module test_txq_weighted_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi_pending = 1'b0, lo_pending = 1'b0, hi_run = 1'b0, lo_run = 1'b0;
  logic [2:0] weight_code = 3'd0;
  logic       pkt_done = 1'b0;
  logic [1:0] grant;
  logic       grant_valid;

  int    n_checks = 0;
  int    n_err = 0;
  string phase = "R1";
  bit    armed = 1'b0;

  logic [1:0] m_grant = 2'b00;
  logic       m_valid = 1'b0;
  int         m_cnt = 0;

  always #5 clk = ~clk;

  txq_weighted_arb i_txq_weighted_arb (
    .clk(clk), .rst_n(rst_n), .hi_pending(hi_pending), .lo_pending(lo_pending),
    .hi_run(hi_run), .lo_run(lo_run), .weight_code(weight_code),
    .pkt_done(pkt_done), .grant(grant), .grant_valid(grant_valid)
  );

  function automatic int quota_of(int c);
    return (c == 0) ? 1 : 2 * c;
  endfunction

  // behavioural reference: one decision per packet boundary
  always @(posedge clk) begin
    if (!rst_n) begin
      m_grant = 2'b00; m_valid = 1'b0; m_cnt = 0;
    end else if (!m_valid || pkt_done) begin
      bit he, le;
      he = hi_pending && hi_run;
      le = lo_pending && lo_run;
      if (!he && !le) begin
        m_grant = 2'b00; m_valid = 1'b0;
      end else if (weight_code == 3'd7) begin
        m_grant = he ? 2'b01 : 2'b10; m_valid = 1'b1; m_cnt = 0;
      end else if (le && (!he || m_cnt >= quota_of(weight_code))) begin
        m_grant = 2'b10; m_valid = 1'b1; m_cnt = 0;
      end else begin
        m_grant = 2'b01; m_valid = 1'b1;
        m_cnt = (m_cnt >= quota_of(weight_code)) ? 1 : m_cnt + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && rst_n) begin
      check(phase, grant, m_grant, "grant vs model");
      check(phase, grant_valid, m_valid, "grant_valid vs model");
      check("R2", int'(grant_valid == (grant != 2'b00) && grant != 2'b11), 1, "grant shape");
    end
  end

  task automatic do_pkt(input int len, input int mid_w, output logic [1:0] g);
    @(negedge clk);
    g = grant;
    for (int i = 1; i < len; i++) begin
      if (i == len / 2 && mid_w >= 0) weight_code = 3'(mid_w);
      @(negedge clk);
    end
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic count_hi(output int n);
    logic [1:0] g;
    n = 0;
    for (int k = 0; k < 30; k++) begin
      do_pkt(2, -1, g);
      if (g == 2'b10) break;
      if (g == 2'b01) n++;
    end
  endtask

  // leaves the count at zero, the current packet is low, next decision sees both
  task automatic drain_count;
    logic [1:0] g;
    hi_pending = 1'b0; lo_pending = 1'b1; hi_run = 1'b1; lo_run = 1'b1;
    do_pkt(2, -1, g);
    hi_pending = 1'b1;
    do_pkt(2, -1, g);
    check("R7", g, 2'b10, "low packet after high drained");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R1..R10 incomplete): actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [1:0] g;
    int n;
    repeat (3) @(negedge clk);
    check("R1", grant, 0, "grant in reset");
    check("R1", grant_valid, 0, "grant_valid in reset");
    hi_pending = 1'b1; lo_pending = 1'b1; hi_run = 1'b1; lo_run = 1'b1;
    rst_n = 1'b1; armed = 1'b1;

    phase = "R5";
    for (int c = 0; c < 7; c++) begin
      weight_code = 3'(c);
      drain_count();
      count_hi(n);
      check("R5", n, quota_of(c), "high run before low");
    end

    phase = "R6";
    weight_code = 3'd7;
    for (int k = 0; k < 15; k++) begin
      do_pkt(3, -1, g);
      if (k > 0) check("R6", g, 2'b01, "strict grant");
    end

    phase = "R7";
    weight_code = 3'd3;
    drain_count();
    for (int k = 0; k < 3; k++) do_pkt(2, -1, g);
    hi_pending = 1'b0;
    do_pkt(2, -1, g);
    hi_pending = 1'b1;
    do_pkt(2, -1, g);
    check("R7", g, 2'b10, "low after high empties mid-run");
    count_hi(n);
    check("R7", n, 6, "run restarts from zero");

    phase = "R8";
    weight_code = 3'd1;
    lo_run = 1'b0;
    for (int k = 0; k < 6; k++) begin
      do_pkt(2, -1, g);
      if (k > 0) check("R8", g, 2'b01, "high continues past quota");
    end
    lo_run = 1'b1;
    count_hi(n);
    check("R8", int'(n <= 2), 1, "low within quota after restart");

    phase = "R9";
    weight_code = 3'd1;
    drain_count();
    hi_pending = 1'b0; lo_pending = 1'b0;
    do_pkt(2, -1, g);
    check("R9", g, 2'b01, "one high before idle");
    repeat (4) @(negedge clk);
    check("R9", grant_valid, 0, "idle when none eligible");
    pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
    check("R3", grant_valid, 0, "done while idle ignored");
    hi_pending = 1'b1; lo_pending = 1'b1;
    count_hi(n);
    check("R9", n, 1, "count kept across idle");

    phase = "R10";
    weight_code = 3'd0;
    drain_count();
    do_pkt(6, 2, g);
    check("R10", g, 2'b01, "first high under old weight");
    count_hi(n);
    check("R10", n, 3, "new weight applied against kept count");

    phase = "R4";
    hi_run = 1'b0;
    for (int k = 0; k < 5; k++) begin
      do_pkt(2, -1, g);
      if (k > 0) check("R4", g, 2'b10, "stopped high not granted");
    end
    hi_run = 1'b1; lo_run = 1'b0; weight_code = 3'd0;
    for (int k = 0; k < 5; k++) begin
      do_pkt(2, -1, g);
      if (k > 0) check("R4", g, 2'b01, "stopped low not granted");
    end
    lo_run = 1'b1;

    phase = "R3";
    for (int k = 0; k < 200; k++) begin
      int len;
      len = 1 + int'($urandom_range(0, 7));
      @(negedge clk);
      for (int i = 0; i < len; i++) begin
        hi_pending = 1'($urandom); lo_pending = 1'($urandom);
        hi_run = 1'($urandom);     lo_run = 1'($urandom);
        weight_code = 3'($urandom);
        @(negedge clk);
      end
      pkt_done = 1'($urandom_range(0, 3) != 0);
      @(negedge clk);
      pkt_done = 1'b0;
    end

    armed = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule